// File: doc/BRIEF.md
# Presettable Binary Down Counter

This block is a loadable down counter, eight bits wide by default. On every rising clock edge where counting is allowed, the value drops by one. When the value is zero and counting is allowed, an active-low zero flag is driven. Two load paths accept a parallel preset word. One is sampled on the clock edge. The other forces the word into the counter at once, with no clock. A master reset forces the counter to its all-ones value at once. Every control input and the zero flag are active low.

Wider counters are built by chaining stages. The zero flag of a lower stage drives the count enable of the next stage. The upper stage then decrements on the same edge where the lower stage wraps from zero to all-ones. There is no streaming data path, so all pins are plain level signals. The current value is brought out so the counter can be observed.

Top module: `preset_down_counter`

## Requirements
- R1: With `rst_n`, `aload_n` and `sload_n` high and `cnt_en_n` low, each rising clock edge lowers `count_val` by exactly one.
- R2: When `count_val` is 0 and counting is enabled, the next rising edge wraps `count_val` to all ones (255 at the default width).
- R3: With `cnt_en_n` high and no load or reset active, `count_val` holds its value across clock edges.
- R4: `zero_n` is low exactly when `count_val` is 0 and `cnt_en_n` is low. It is high whenever `cnt_en_n` is high, including when the count is zero. During a count-down it is low for one clock period.
- R5: When `sload_n` is low at a rising edge, `count_val` takes `preset_val` on that edge, whatever `cnt_en_n` is.
- R6: When `aload_n` is low, `count_val` equals `preset_val` at once, without a clock edge. This overrides `sload_n`, `cnt_en_n` and the clock.
- R7: After `aload_n` returns high, the first rising edge with counting enabled gives the loaded value minus one. Releasing the load causes no extra step.
- R8: When `rst_n` is low, `count_val` is forced at once to all ones. This overrides every other input.
- R9: When the `zero_n` of a low stage drives the `cnt_en_n` of a high stage, the pair counts down as one 16-bit value. The high stage supplies bits 15..8 and wraps from 0x0000 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous master reset to all ones, active low |
| aload_n | input | 1 | Asynchronous preset load, active low |
| sload_n | input | 1 | Synchronous preset load, active low |
| cnt_en_n | input | 1 | Count enable, active low; high holds the count |
| preset_val | input | WIDTH | Parallel preset word |
| count_val | output | WIDTH | Current counter value |
| zero_n | output | 1 | Zero flag, active low, qualified by `cnt_en_n` |

## Verification
The bench sweeps all 256 preset words through the synchronous load. For each word it checks one decrement step. This covers the wrap from zero, where a design that saturated or stopped at zero would hold at 0 instead of showing 255. The sweep also toggles the count enable. A zero flag that ignored the enable would go low at a zero count while the counter is held. A synchronous load gated by the enable would fail to load on the odd words. The asynchronous load is checked before any clock edge, then at the first edge after release: a design that stepped on release would show the loaded value minus two. A chained pair is counted through 0x0000 to catch a carry that fires one edge late or on the wrong condition.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  // Action taken by the counter on a rising clock edge.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DEC  = 2'd1,
    STEP_LOAD = 2'd2
  } step_t;
endpackage

// File: rtl/dcnt_step_sel.sv
module dcnt_step_sel
  import dcnt_pkg::*;
(
  input  logic  sload_n,
  input  logic  cnt_en_n,
  output step_t step
);
  // Synchronous load wins over the enable; the enable picks decrement or hold.
  always_comb begin
    if (!sload_n)       step = STEP_LOAD;
    else if (!cnt_en_n) step = STEP_DEC;
    else                step = STEP_HOLD;
  end
endmodule

// File: rtl/dcnt_next.sv
module dcnt_next
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  step_t            step,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // Modulo-2^WIDTH subtraction makes zero wrap to all ones.
  always_comb begin
    case (step)
      STEP_LOAD: nxt = preset;
      STEP_DEC:  nxt = cur - ONE;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/dcnt_state.sv
module dcnt_state #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aload_n,
  input  logic [WIDTH-1:0] preset,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  // Reset beats the asynchronous load; both beat the clocked path.
  always_ff @(posedge clk or negedge rst_n or negedge aload_n) begin
    if (!rst_n)        q <= FULL;
    else if (!aload_n) q <= preset;
    else               q <= nxt;
  end
endmodule

// File: rtl/dcnt_zero.sv
module dcnt_zero #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q,
  input  logic             cnt_en_n,
  output logic             zero_n
);
  // Low only when the count is zero and counting is enabled.
  assign zero_n = (|q) | cnt_en_n;
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aload_n,
  input  logic             sload_n,
  input  logic             cnt_en_n,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count_val,
  output logic             zero_n
);
  step_t            step;
  logic [WIDTH-1:0] nxt;

  dcnt_step_sel u_sel (
    .sload_n  (sload_n),
    .cnt_en_n (cnt_en_n),
    .step     (step)
  );

  dcnt_next #(.WIDTH(WIDTH)) u_next (
    .step   (step),
    .cur    (count_val),
    .preset (preset_val),
    .nxt    (nxt)
  );

  dcnt_state #(.WIDTH(WIDTH)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .aload_n (aload_n),
    .preset  (preset_val),
    .nxt     (nxt),
    .q       (count_val)
  );

  dcnt_zero #(.WIDTH(WIDTH)) u_zero (
    .q        (count_val),
    .cnt_en_n (cnt_en_n),
    .zero_n   (zero_n)
  );
endmodule

// File: rtl/preset_down_counter_chk.sv
module preset_down_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             aload_n,
  input logic             sload_n,
  input logic             cnt_en_n,
  input logic [WIDTH-1:0] preset_val,
  input logic [WIDTH-1:0] count_val,
  input logic             zero_n
);
  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  // R1 and R2: an enabled step lowers the count by one, modulo 2^WIDTH.
  assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(aload_n) && aload_n && $past(sload_n) && !$past(cnt_en_n))
      |-> (count_val == $past(count_val) - ONE));

  // R3: a disabled counter keeps its value.
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(aload_n) && aload_n && $past(sload_n) && $past(cnt_en_n))
      |-> $stable(count_val));

  // R4: the flag is never low while the enable is high.
  assert_flag_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_n |-> zero_n);

  // R4: the flag lasts one period when the counter wraps.
  assert_flag_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_n && sload_n && aload_n) |=> zero_n);

  // R5: the synchronous load takes the word sampled at the edge.
  assert_sync_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(aload_n) && aload_n && !$past(sload_n))
      |-> (count_val == $past(preset_val)));

  // R6: the asynchronous load holds the preset word.
  assert_async_load_R6: assert property (@(posedge clk)
    (rst_n && !aload_n) |-> (count_val == preset_val));

  // R8: reset holds the counter at all ones.
  assert_reset_full_R8: assert property (@(posedge clk)
    !rst_n |-> (count_val == FULL));
endmodule

bind preset_down_counter preset_down_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/preset_down_counter_test.sv
module preset_down_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       aload_n = 1'b1;
  logic       sload_n = 1'b1;
  logic       cnt_en_n = 1'b1;
  logic [7:0] preset_val = 8'h00;
  logic [7:0] preset_hi = 8'h00;
  logic [7:0] count_val;
  logic [7:0] count_hi;
  logic       zero_n;
  logic       zero_hi_n;

  int ncheck = 0;
  int nfail  = 0;

  always #4 clk = ~clk;

  preset_down_counter #(.WIDTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .aload_n(aload_n), .sload_n(sload_n),
    .cnt_en_n(cnt_en_n), .preset_val(preset_val),
    .count_val(count_val), .zero_n(zero_n)
  );

  // Upper stage of a synchronous chain: enabled by the lower stage's flag.
  preset_down_counter #(.WIDTH(8)) uut_hi (
    .clk(clk), .rst_n(rst_n), .aload_n(aload_n), .sload_n(sload_n),
    .cnt_en_n(zero_n), .preset_val(preset_hi),
    .count_val(count_hi), .zero_n(zero_hi_n)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    ncheck++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end

  initial begin
    // R8: reset acts at once and overrides both loads and the enable.
    #1;
    preset_val = 8'h5A;
    rst_n = 1'b0;
    #1;
    check("R8 reset immediate", {8'h0, count_val}, 16'h00FF);
    check("R4 flag high after reset", {15'h0, zero_n}, 16'h0001);
    aload_n = 1'b0; sload_n = 1'b0; cnt_en_n = 1'b0;
    tick();
    tick();
    check("R8 reset overrides loads", {8'h0, count_val}, 16'h00FF);
    aload_n = 1'b1; sload_n = 1'b1; cnt_en_n = 1'b1;
    rst_n = 1'b1;
    tick();
    check("R3 hold after reset", {8'h0, count_val}, 16'h00FF);

    // R5, R1, R2, R3, R4: sweep every preset word.
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pv;
      pv = 8'(p);
      preset_val = pv;
      sload_n = 1'b0;
      cnt_en_n = pv[0];
      tick();
      sload_n = 1'b1;
      check("R5 sync load", {8'h0, count_val}, {8'h0, pv});
      check("R4 flag after load", {15'h0, zero_n},
            {15'h0, !((pv == 8'h00) && !pv[0])});
      cnt_en_n = 1'b0;
      #1;
      check("R4 flag enabled", {15'h0, zero_n}, {15'h0, pv != 8'h00});
      tick();
      if (pv == 8'h00) check("R2 wrap to 255", {8'h0, count_val}, 16'h00FF);
      else             check("R1 decrement", {8'h0, count_val}, {8'h0, pv - 8'h01});
      cnt_en_n = 1'b1;
      #1;
      check("R4 flag gated by enable", {15'h0, zero_n}, 16'h0001);
      tick();
      check("R3 hold", {8'h0, count_val}, {8'h0, pv - 8'h01});
    end

    // R6, R7: asynchronous load, then release with no extra step.
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = 8'(k * 67 + 1);
      preset_val = v;
      cnt_en_n = 1'b0;
      aload_n = 1'b0;
      #1;
      check("R6 async load immediate", {8'h0, count_val}, {8'h0, v});
      sload_n = 1'b0;
      tick();
      check("R6 async load overrides clock", {8'h0, count_val}, {8'h0, v});
      aload_n = 1'b1;
      sload_n = 1'b1;
      #1;
      check("R7 no step on release", {8'h0, count_val}, {8'h0, v});
      tick();
      check("R7 resume from loaded value", {8'h0, count_val}, {8'h0, v - 8'h01});
      cnt_en_n = 1'b1;
      tick();
    end

    // R4: full count-down, flag low on exactly one cycle.
    preset_val = 8'hFF;
    sload_n = 1'b0;
    tick();
    sload_n = 1'b1;
    cnt_en_n = 1'b0;
    for (int i = 255; i >= 0; i--) begin
      #1;
      check("R1 countdown value", {8'h0, count_val}, 16'(i));
      check("R4 countdown flag", {15'h0, zero_n}, {15'h0, i != 0});
      tick();
    end
    check("R2 wrap after countdown", {8'h0, count_val}, 16'h00FF);

    // R9: two chained stages count as one 16-bit value.
    begin
      logic [15:0] exp16;
      exp16 = 16'h0203;
      cnt_en_n = 1'b1;
      preset_val = exp16[7:0];
      preset_hi = exp16[15:8];
      sload_n = 1'b0;
      tick();
      sload_n = 1'b1;
      check("R9 chain load", {count_hi, count_val}, exp16);
      cnt_en_n = 1'b0;
      for (int i = 0; i < 600; i++) begin
        tick();
        exp16 = exp16 - 16'h0001;
        check("R9 chain count", {count_hi, count_val}, exp16);
      end
      cnt_en_n = 1'b1;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end
endmodule